// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block moves an 18-bit word in two directions between port A and port B. Each direction has its own storage cell, its own pass-through enable, its own direction strobe and its own drive enable. In place of three-state pads, each port gives a data word and a separate drive-enable flag, which the pad ring turns into a real output driver.

Each storage cell works in one of three ways, set by its enable and its strobe. With the pass-through enable high, the cell is transparent and the far port follows the near one. With the pass-through enable low and the strobe steady, the cell holds its word. A high-to-low strobe transition loads a new word into the cell.

All controls and data are sampled on one system clock. A strobe edge is found by comparing two sampled levels. A small state machine in each cell records whether the strobe has been seen low since pass-through ended. A strobe that is already high when pass-through drops therefore cannot load the cell when it later falls. The A-to-B drive enable is active high and the B-to-A drive enable is active low.

Top module: `xcvr_bidir`

## Requirements
- R1: A cycle with `rst` high clears both stored words to zero and turns off both drive flags; on the next clock edge `b_out`, `a_out`, `b_drv` and `a_drv` are all 0.
- R2: Input values at cycle n reach the outputs at cycle n+2. When `ab_pass` is 1 in cycle n, `b_out` in cycle n+2 equals `a_in` of cycle n.
- R3: When `ab_pass` goes from 1 to 0, `b_out` keeps the `a_in` value from the last cycle in which `ab_pass` was 1.
- R4: While `ab_pass` is 0 and `ab_strobe` keeps one level, `b_out` does not change, whatever `a_in` does.
- R5: While `ab_pass` is 0, a sampled `ab_strobe` of 1 in cycle n-1 followed by 0 in cycle n loads `a_in` of cycle n. The new word shows on `b_out` in cycle n+2. This holds only if the strobe was already seen at 0 after `ab_pass` fell.
- R6: If `ab_strobe` is 1 in the first cycle with `ab_pass` at 0, its next fall loads nothing. Only a later 1-to-0 transition of the strobe loads a word.
- R7: `b_drv` in cycle n+2 equals `ab_drive` of cycle n (active high), and the drive flag has no effect on `b_out`.
- R8: While a port's drive flag is 0, its storage cell still follows in pass-through and still loads on strobe falls, so that port's data output keeps changing.
- R9: The B-to-A direction follows R2 to R8 with `ba_pass`, `ba_strobe`, `b_in` and `a_out`. Its drive input `ba_drive_n` is active low: `a_drv` in cycle n+2 equals the inverse of `ba_drive_n` in cycle n.
- R10: The two directions are independent. A load, hold or pass-through in one direction in a given cycle has no effect on the other direction in that cycle.
- R11: When `ab_pass` rises in the same cycle as a strobe fall, pass-through wins and the word of that cycle is taken. When `ab_pass` falls in the same cycle as a strobe fall, nothing is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Word received on port A |
| b_in | input | 18 | Word received on port B |
| ab_pass | input | 1 | A-to-B pass-through enable, 1 = transparent |
| ab_strobe | input | 1 | A-to-B strobe, loads on a 1-to-0 transition |
| ab_drive | input | 1 | A-to-B drive enable, active high |
| ba_pass | input | 1 | B-to-A pass-through enable, 1 = transparent |
| ba_strobe | input | 1 | B-to-A strobe, loads on a 1-to-0 transition |
| ba_drive_n | input | 1 | B-to-A drive enable, active low |
| b_out | output | 18 | Word driven toward port B |
| b_drv | output | 1 | Port B driver on |
| a_out | output | 18 | Word driven toward port A |
| a_drv | output | 1 | Port A driver on |

## Verification
The hard cases are the cycles in which a change of the pass-through enable meets a strobe fall in the same direction. In such a cycle the cell could either take the word as pass-through or load it on the edge. The bench drives both orderings on purpose: the enable rising together with a fall, and the enable dropping together with a fall. It then checks the port two cycles later against a reference that only tracks whether the strobe has been seen low since pass-through ended. A long random run then mixes all of these events across both directions at once, and each output word is compared cycle by cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    parameter int XCVR_WIDTH = 18;
    parameter int XCVR_NDIR  = 2;

    // Cell modes: FOLLOW = transparent; WAIT_LOW = strobe not yet seen
    // low since pass-through ended; ARM_LOW / ARM_HIGH = armed, last
    // sampled strobe level low / high.
    typedef enum logic [1:0] {
        CELL_FOLLOW   = 2'd0,
        CELL_WAIT_LOW = 2'd1,
        CELL_ARM_LOW  = 2'd2,
        CELL_ARM_HIGH = 2'd3
    } cell_state_e;

endpackage

// File: rtl/xcvr_sampler.sv
module xcvr_sampler #(
    parameter int W             = xcvr_pkg::XCVR_WIDTH,
    parameter bit EN_ACTIVE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_raw,
    input  logic         pass_raw,
    input  logic         strobe_raw,
    input  logic         drive_raw,
    output logic [W-1:0] d_q,
    output logic         pass_q,
    output logic         strobe_q,
    output logic         en_q
);

    logic en_raw;

    generate
        if (EN_ACTIVE_LOW) begin : g_inv
            assign en_raw = ~drive_raw;
        end else begin : g_pass
            assign en_raw = drive_raw;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q      <= '0;
            pass_q   <= 1'b0;
            strobe_q <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            d_q      <= d_raw;
            pass_q   <= pass_raw;
            strobe_q <= strobe_raw;
            en_q     <= en_raw;
        end
    end

endmodule

// File: rtl/xcvr_cell.sv
module xcvr_cell #(
    parameter int W = xcvr_pkg::XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_q,
    input  logic         pass_q,
    input  logic         strobe_q,
    output logic [W-1:0] word
);
    import xcvr_pkg::*;

    cell_state_e cur, nxt;
    logic        take;

    // Next mode and load decision
    always_comb begin
        nxt  = cur;
        take = 1'b0;
        if (pass_q) begin
            nxt  = CELL_FOLLOW;
            take = 1'b1;
        end else begin
            unique case (cur)
                CELL_FOLLOW:   nxt = strobe_q ? CELL_WAIT_LOW : CELL_ARM_LOW;
                CELL_WAIT_LOW: if (!strobe_q) nxt = CELL_ARM_LOW;
                CELL_ARM_LOW:  if (strobe_q)  nxt = CELL_ARM_HIGH;
                CELL_ARM_HIGH: if (!strobe_q) begin
                    nxt  = CELL_ARM_LOW;
                    take = 1'b1;
                end
                default:       nxt = CELL_WAIT_LOW;
            endcase
        end
    end

    // Mode register
    always_ff @(posedge clk) begin
        if (rst) cur <= CELL_WAIT_LOW;
        else     cur <= nxt;
    end

    // Stored word
    always_ff @(posedge clk) begin
        if (rst)       word <= '0;
        else if (take) word <= d_q;
    end

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir #(
    parameter int W             = xcvr_pkg::XCVR_WIDTH,
    parameter bit EN_ACTIVE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_raw,
    input  logic         pass_raw,
    input  logic         strobe_raw,
    input  logic         drive_raw,
    output logic [W-1:0] q_word,
    output logic         q_drv
);

    logic [W-1:0] d_q;
    logic         pass_q, strobe_q, en_q;

    xcvr_sampler #(.W(W), .EN_ACTIVE_LOW(EN_ACTIVE_LOW)) u_smp (
        .clk        (clk),
        .rst        (rst),
        .d_raw      (d_raw),
        .pass_raw   (pass_raw),
        .strobe_raw (strobe_raw),
        .drive_raw  (drive_raw),
        .d_q        (d_q),
        .pass_q     (pass_q),
        .strobe_q   (strobe_q),
        .en_q       (en_q)
    );

    xcvr_cell #(.W(W)) u_cell (
        .clk      (clk),
        .rst      (rst),
        .d_q      (d_q),
        .pass_q   (pass_q),
        .strobe_q (strobe_q),
        .word     (q_word)
    );

    // Drive flag delayed to line up with the stored word
    always_ff @(posedge clk) begin
        if (rst) q_drv <= 1'b0;
        else     q_drv <= en_q;
    end

endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir #(
    parameter int W = xcvr_pkg::XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_pass,
    input  logic         ab_strobe,
    input  logic         ab_drive,
    input  logic         ba_pass,
    input  logic         ba_strobe,
    input  logic         ba_drive_n,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    output logic [W-1:0] a_out,
    output logic         a_drv
);
    localparam int NDIR = xcvr_pkg::XCVR_NDIR;

    logic [NDIR-1:0][W-1:0] d_in, d_out;
    logic [NDIR-1:0]        pass_v, strobe_v, drive_v, drv_v;

    // Index 0: A to B, index 1: B to A
    assign d_in     = {b_in, a_in};
    assign pass_v   = {ba_pass, ab_pass};
    assign strobe_v = {ba_strobe, ab_strobe};
    assign drive_v  = {ba_drive_n, ab_drive};

    generate
        for (genvar g = 0; g < NDIR; g++) begin : g_dir
            xcvr_dir #(.W(W), .EN_ACTIVE_LOW(g == 1)) u_dir (
                .clk        (clk),
                .rst        (rst),
                .d_raw      (d_in[g]),
                .pass_raw   (pass_v[g]),
                .strobe_raw (strobe_v[g]),
                .drive_raw  (drive_v[g]),
                .q_word     (d_out[g]),
                .q_drv      (drv_v[g])
            );
        end
    endgenerate

    assign b_out = d_out[0];
    assign b_drv = drv_v[0];
    assign a_out = d_out[1];
    assign a_drv = drv_v[1];

endmodule

// File: rtl/xcvr_bidir_chk.sv
module xcvr_bidir_chk #(
    parameter int W = xcvr_pkg::XCVR_WIDTH
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_pass,
    input logic         ab_strobe,
    input logic         ab_drive,
    input logic         ba_pass,
    input logic         ba_strobe,
    input logic         ba_drive_n,
    input logic [W-1:0] b_out,
    input logic         b_drv,
    input logic [W-1:0] a_out,
    input logic         a_drv
);
    logic [2:0] age;
    logic       ok;

    always_ff @(posedge clk) begin
        if (rst)              age <= 3'd0;
        else if (age != 3'd5) age <= age + 3'd1;
    end
    assign ok = (age == 3'd5);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (b_out == '0 && a_out == '0 && !b_drv && !a_drv));

    assert_follow_ab_R2: assert property (@(posedge clk) disable iff (rst)
        ok && $past(ab_pass, 2) |-> b_out == $past(a_in, 2));

    assert_follow_ba_R9: assert property (@(posedge clk) disable iff (rst)
        ok && $past(ba_pass, 2) |-> a_out == $past(b_in, 2));

    assert_hold_ab_R4: assert property (@(posedge clk) disable iff (rst)
        ok && !$past(ab_pass, 2) && b_out != $past(b_out)
        |-> $past(ab_strobe, 3) && !$past(ab_strobe, 2));

    assert_hold_ba_R9: assert property (@(posedge clk) disable iff (rst)
        ok && !$past(ba_pass, 2) && a_out != $past(a_out)
        |-> $past(ba_strobe, 3) && !$past(ba_strobe, 2));

    assert_drive_ab_R7: assert property (@(posedge clk) disable iff (rst)
        ok |-> b_drv == $past(ab_drive, 2));

    assert_drive_ba_R9: assert property (@(posedge clk) disable iff (rst)
        ok |-> a_drv == !$past(ba_drive_n, 2));

endmodule

bind xcvr_bidir xcvr_bidir_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .b_in       (b_in),
    .ab_pass    (ab_pass),
    .ab_strobe  (ab_strobe),
    .ab_drive   (ab_drive),
    .ba_pass    (ba_pass),
    .ba_strobe  (ba_strobe),
    .ba_drive_n (ba_drive_n),
    .b_out      (b_out),
    .b_drv      (b_drv),
    .a_out      (a_out),
    .a_drv      (a_drv)
);

// File: tb/tb_xcvr_bidir.sv
module tb_xcvr_bidir;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_pass = 0, ab_strobe = 0, ab_drive = 0;
    logic         ba_pass = 0, ba_strobe = 0, ba_drive_n = 1;
    logic [W-1:0] b_out, a_out;
    logic         b_drv, a_drv;

    always #2 clk = ~clk;

    xcvr_bidir #(.W(W)) dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
        .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n),
        .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
    );

    typedef struct {
        int           due;
        string        tag;
        logic [W-1:0] eb;
        logic         eb_drv;
        logic [W-1:0] ea;
        logic         ea_drv;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_run = 0, n_fail = 0;
    bit    done = 0;

    // Reference state per direction: word, armed flag, last strobe level
    logic [W-1:0] m_wb = '0, m_wa = '0;
    logic         m_armb = 0, m_arma = 0, m_pb = 0, m_pa = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic ref_dir(input logic p, input logic s, input logic [W-1:0] d,
                           inout logic [W-1:0] wd, inout logic arm, inout logic ps);
        if (p) begin
            wd  = d;
            arm = 1'b0;
        end else begin
            if (arm && ps && !s) wd = d;
            if (!s) arm = 1'b1;
        end
        ps = s;
    endtask

    task automatic push(input int due, input string tag, input logic [W-1:0] eb,
                        input logic ebd, input logic [W-1:0] ea, input logic ead);
        item_t it;
        it.due = due; it.tag = tag; it.eb = eb; it.eb_drv = ebd;
        it.ea = ea; it.ea_drv = ead;
        q.push_back(it);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        while (q.size() > 0 && q[$].due > cyc) void'(q.pop_back());
        push(cyc + 1, "R1", '0, 1'b0, '0, 1'b0);
        m_wb = '0; m_wa = '0; m_armb = 0; m_arma = 0; m_pb = 0; m_pa = 0;
        ref_dir(1'b0, 1'b0, '0, m_wb, m_armb, m_pb);
        ref_dir(1'b0, 1'b0, '0, m_wa, m_arma, m_pa);
        push(cyc + 2, "R1", m_wb, 1'b0, m_wa, 1'b0);
    endtask

    task automatic step(input logic pab, input logic sab, input logic dab,
                        input logic [W-1:0] da,
                        input logic pba, input logic sba, input logic dban,
                        input logic [W-1:0] db, input string tag);
        @(negedge clk);
        rst = 1'b0;
        ab_pass = pab; ab_strobe = sab; ab_drive = dab; a_in = da;
        ba_pass = pba; ba_strobe = sba; ba_drive_n = dban; b_in = db;
        ref_dir(pab, sab, da, m_wb, m_armb, m_pb);
        ref_dir(pba, sba, db, m_wa, m_arma, m_pa);
        push(cyc + 2, tag, m_wb, dab, m_wa, !dban);
    endtask

    // Monitor: compare items due in this cycle, away from the edge
    always @(posedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            n_run++;
            if (b_out !== it.eb || b_drv !== it.eb_drv ||
                a_out !== it.ea || a_drv !== it.ea_drv) begin
                n_fail++;
                $display("FAIL %s cyc=%0d got b=%h/%b a=%h/%b exp b=%h/%b a=%h/%b",
                         it.tag, cyc, b_out, b_drv, a_out, a_drv,
                         it.eb, it.eb_drv, it.ea, it.ea_drv);
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        do_reset();
        // R2 + R8: A-to-B transparent and driven; B-to-A transparent, not driven
        for (int i = 0; i < 5; i++)
            step(1, 0, 1, 18'h1000 + W'(i * 37), 1, 0, 1, 18'h2A000 - W'(i), "R2 R8");
        // R3: pass-through drops with strobe low, word kept
        step(0, 0, 1, 18'h3FFFF, 1, 0, 1, 18'h00111, "R3");
        step(0, 0, 1, 18'h00001, 1, 0, 1, 18'h00222, "R3");
        // R4: strobe rises and stays high, input ignored
        step(0, 1, 1, 18'h0BEEF, 1, 0, 1, 18'h00333, "R4");
        step(0, 1, 1, 18'h0CAFE, 1, 0, 1, 18'h00444, "R4");
        step(0, 1, 1, 18'h15555, 1, 0, 1, 18'h00555, "R4");
        // R5: strobe fall loads that cycle's word
        step(0, 0, 1, 18'h2AAAA, 0, 0, 1, 18'h00666, "R5");
        step(0, 0, 1, 18'h00777, 0, 0, 1, 18'h00888, "R5");
        step(0, 1, 1, 18'h01234, 0, 0, 1, 18'h00999, "R5");
        step(0, 0, 1, 18'h04321, 0, 0, 1, 18'h00AAA, "R5");
        // R6: strobe already high when pass-through drops
        step(1, 1, 1, 18'h11111, 0, 0, 1, 18'h0, "R6");
        step(0, 1, 1, 18'h22222, 0, 0, 1, 18'h0, "R6");
        step(0, 0, 1, 18'h33333, 0, 0, 1, 18'h0, "R6");
        step(0, 1, 1, 18'h04444, 0, 0, 1, 18'h0, "R6");
        step(0, 0, 1, 18'h05555, 0, 0, 1, 18'h0, "R6");
        // R7: drive flag toggles, data unaffected
        step(1, 0, 0, 18'h00ABC, 0, 0, 1, 18'h0, "R7");
        step(1, 0, 1, 18'h00ABD, 0, 0, 1, 18'h0, "R7");
        step(1, 0, 0, 18'h00ABE, 0, 0, 1, 18'h0, "R7");
        // R8: loads while not driven
        step(0, 0, 0, 18'h00F00, 0, 0, 1, 18'h0, "R8");
        step(0, 1, 0, 18'h00F01, 0, 0, 1, 18'h0, "R8");
        step(0, 0, 0, 18'h00F02, 0, 0, 1, 18'h0, "R8");
        // R9: B-to-A with active-low drive
        step(0, 0, 1, 18'h0, 1, 0, 0, 18'h12345, "R9");
        step(0, 0, 1, 18'h0, 1, 1, 0, 18'h23456, "R9");
        step(0, 1, 1, 18'h0, 0, 1, 0, 18'h34567, "R9");
        step(0, 0, 1, 18'h0, 0, 0, 1, 18'h01010, "R9");
        step(0, 0, 1, 18'h0, 0, 1, 0, 18'h02020, "R9");
        step(0, 0, 1, 18'h0, 0, 0, 0, 18'h03030, "R9");
        // R10: load in A-to-B while B-to-A is transparent, same cycles
        step(0, 1, 1, 18'h0AAAA, 1, 0, 0, 18'h05050, "R10");
        step(0, 0, 1, 18'h0BBBB, 1, 1, 0, 18'h06060, "R10");
        step(0, 0, 1, 18'h0CCCC, 1, 0, 0, 18'h07070, "R10");
        // R11: pass-through rises with a strobe fall; falls with a strobe fall
        step(0, 1, 1, 18'h00011, 0, 1, 0, 18'h0, "R11");
        step(1, 0, 1, 18'h00022, 0, 1, 0, 18'h0, "R11");
        step(1, 1, 1, 18'h00033, 0, 1, 0, 18'h0, "R11");
        step(0, 0, 1, 18'h00044, 0, 1, 0, 18'h0, "R11");
        step(0, 0, 1, 18'h00055, 0, 1, 0, 18'h0, "R11");
        // R1: reset in the middle of activity
        do_reset();
        step(0, 1, 1, 18'h3F00F, 0, 1, 0, 18'h0F0F0, "R1");
        step(0, 0, 1, 18'h3F00E, 0, 0, 0, 18'h0F0F1, "R1");
        // R10: long random mix of both directions
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom;
            step(r[2:0] == 3'd0, r[3], r[4], W'($urandom),
                 r[7:5] == 3'd0, r[8], r[9], W'($urandom), "R10");
        end
        repeat (4) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule